// File: doc/BRIEF.md
# Command Packet Taskfile Sequencer

This block executes one disk command packet that software has already placed in a small local packet memory. On a single-cycle `go` pulse it reads the packet header to get the control flags, the length code and the data-descriptor pointer. It then walks the register list that starts at byte 16. Each entry is a pair of bytes, the value first and then a register address carrying flag bits. Every entry that is not marked to be skipped becomes one write on the device register port.

Once the entry carrying the end mark has been handled, the block may hand the descriptor pointer to a downstream data-transfer stage and wait for it to finish. It then reports completion by overwriting byte 0 of the packet, the response byte. A packet that is not marked valid, or a register list that runs past its length bound, ends with a protocol-error pulse and leaves the response byte untouched. A synchronous engine reset aborts any run.

The device register port is a valid/ready stream. While `dev_valid` is high and `dev_ready` is low, the block holds `dev_addr` and `dev_data` steady and does not withdraw the write. A write counts as done on a clock edge where both are high. The packet memory read port has a fixed latency of one cycle. All other pins are plain control and status signals.

Top module: `tfs_seq`

## Requirements
- R1: After reset, `busy`, `dev_valid`, `mem_wr_en`, `xfer_start`, `proto_err` and `irq` are all low.
- R2: The flags are header byte 2 and the length code is header byte 3. In the flags byte, bit 0 = valid, bit 2 = data phase, bit 3 = interrupt enable. If bit 0 is clear, the block issues no device write and no response write, gives a one-cycle `proto_err`, and returns to idle.
- R3: Register entries start at byte 16 and come as pairs: the value byte, then the address byte. Each write carries `dev_data` = the value and `dev_addr` = address bits 4:0, and the writes go out in packet order.
- R4: An entry whose address byte has bit 5 set produces no device write.
- R5: An entry whose address byte has bit 7 set is the last one. Its write is still issued unless bit 5 is also set, and no later bytes are read as entries.
- R6: With length code L, entries may occupy bytes up to (L+3)*8-1. If the list reaches that bound without an end mark, the writes already made stand, `proto_err` pulses, and no response is written.
- R7: While `dev_valid` is high and `dev_ready` is low, `dev_valid`, `dev_addr` and `dev_data` hold their values into the next cycle.
- R8: With the data flag set, after the last write `xfer_start` pulses for exactly one cycle. `xfer_ptr` then equals the little-endian word in header bytes 8..11. The response is written only in a cycle after `xfer_done` has been seen.
- R9: With the data flag clear, `xfer_start` never pulses and the response is written after the last device write.
- R10: The response write goes to address 0. Its value is 0x01 if `dev_err` is low in the write cycle, and 0x09 (bit 3 added) if it is high.
- R11: `irq` pulses in the response-write cycle exactly when flags bit 3 is set.
- R12: A synchronous `eng_rst` returns the block to idle on the next edge from any state, with no response write.
- R13: A `go` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_rst | input | 1 | Synchronous engine reset to idle |
| go | input | 1 | Single-cycle start pulse |
| busy | output | 1 | High while a packet is being processed |
| mem_rd_en | output | 1 | Packet memory read request |
| mem_rd_addr | output | PM_AW | Packet memory read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Response byte write strobe |
| mem_wr_addr | output | PM_AW | Response write address (always 0) |
| mem_wr_data | output | 8 | Response code |
| dev_valid | output | 1 | Device register write valid |
| dev_ready | input | 1 | Device accepts the write |
| dev_addr | output | 5 | Device register address |
| dev_data | output | 8 | Device register value |
| dev_err | input | 1 | Device error indication at completion |
| xfer_start | output | 1 | Start strobe to the data-transfer stage |
| xfer_ptr | output | 32 | First data descriptor address |
| xfer_done | input | 1 | Data-transfer stage finished |
| proto_err | output | 1 | Packet rejected (one-cycle pulse) |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The main function is exercised with five packet shapes. A 28-bit-address command with a skipped pad entry and the interrupt flag set separates skipping from writing and checks the interrupt pulse. A 48-bit-address command with a data phase, a stalling device port and a device error checks hold-under-back-pressure, pointer assembly and the error code. An invalid packet and a list with no end mark produce the two protocol-error paths, which differ in whether writes come before the pulse. A data-phase packet aborted by engine reset and a repeated `go` during a run show that neither leaves an extra response or extra writes behind.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HREQ, ST_HCAP, ST_VREQ, ST_VCAP, ST_AREQ, ST_ACAP,
    ST_ISSUE, ST_NEXT, ST_XSTART, ST_XWAIT, ST_RESP, ST_ERR
  } seq_state_t;

  localparam int FLG_VALID  = 0;
  localparam int FLG_DATA   = 2;
  localparam int FLG_IRQ    = 3;
  localparam int ADR_SKIP   = 5;
  localparam int ADR_LAST   = 7;
  localparam int PAIR_BASE  = 16;
  localparam int BYTE_FLAGS = 2;
  localparam int BYTE_LEN   = 3;
  localparam int BYTE_PTR0  = 8;
  localparam int BYTE_PTR3  = 11;
  localparam logic [7:0] RESP_OK = 8'h01;
  localparam int RESP_DEVERR_BIT = 3;
endpackage

// File: rtl/tfs_pair_dec.sv
module tfs_pair_dec #(
  parameter int RA_W = 5
) (
  input  logic [7:0]      adr_byte,
  output logic            skip,
  output logic            last,
  output logic [RA_W-1:0] reg_addr
);
  import tfs_pkg::*;

  always_comb begin
    skip     = adr_byte[ADR_SKIP];
    last     = adr_byte[ADR_LAST];
    reg_addr = adr_byte[RA_W-1:0];
  end
endmodule

// File: rtl/tfs_ptr_asm.sv
module tfs_ptr_asm #(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]             din,
  output logic [LANES*8-1:0]     ptr
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ptr[g*8 +: 8] <= '0;
      else if (clr)                      ptr[g*8 +: 8] <= '0;
      else if (we && lane == g)          ptr[g*8 +: 8] <= din;
    end
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);
endmodule

// File: rtl/tfs_seq.sv
module tfs_seq #(
  parameter int PM_AW = 12,
  parameter int RA_W  = 5,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_rst,
  input  logic             go,
  output logic             busy,
  output logic             mem_rd_en,
  output logic [PM_AW-1:0] mem_rd_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             mem_wr_en,
  output logic [PM_AW-1:0] mem_wr_addr,
  output logic [7:0]       mem_wr_data,
  output logic             dev_valid,
  input  logic             dev_ready,
  output logic [RA_W-1:0]  dev_addr,
  output logic [7:0]       dev_data,
  input  logic             dev_err,
  output logic             xfer_start,
  output logic [PTR_W-1:0] xfer_ptr,
  input  logic             xfer_done,
  output logic             proto_err,
  output logic             irq
);
  import tfs_pkg::*;

  localparam int LANES = PTR_W / 8;
  localparam int LN_W  = $clog2(LANES);
  localparam logic [PM_AW-1:0] IDX_FLAGS = PM_AW'(BYTE_FLAGS);
  localparam logic [PM_AW-1:0] IDX_LEN   = PM_AW'(BYTE_LEN);
  localparam logic [PM_AW-1:0] IDX_PTR0  = PM_AW'(BYTE_PTR0);
  localparam logic [PM_AW-1:0] IDX_PTR3  = PM_AW'(BYTE_PTR3);
  localparam logic [PM_AW-1:0] IDX_PAIRS = PM_AW'(PAIR_BASE);

  seq_state_t       state;
  logic [PM_AW-1:0] idx, lim;
  logic [7:0]       flags, val_q, adr_q;
  logic             skip, last;
  logic [RA_W-1:0]  reg_addr;
  logic             ptr_we;

  tfs_pair_dec #(.RA_W(RA_W)) u_dec (
    .adr_byte(adr_q), .skip(skip), .last(last), .reg_addr(reg_addr)
  );

  assign ptr_we = (state == ST_HCAP) && (idx >= IDX_PTR0) && (idx <= IDX_PTR3);

  tfs_ptr_asm #(.LANES(LANES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE && go && !eng_rst),
    .we(ptr_we), .lane(idx[LN_W-1:0]), .din(mem_rd_data), .ptr(xfer_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      lim   <= '0;
      flags <= '0;
      val_q <= '0;
      adr_q <= '0;
    end else if (eng_rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          idx   <= IDX_FLAGS;
          state <= ST_HREQ;
        end
        ST_HREQ: state <= ST_HCAP;
        ST_HCAP: begin
          state <= ST_HREQ;
          if (idx == IDX_FLAGS) begin
            flags <= mem_rd_data;
            idx   <= IDX_LEN;
            if (!mem_rd_data[FLG_VALID]) state <= ST_ERR;
          end else if (idx == IDX_LEN) begin
            lim <= (PM_AW'(mem_rd_data) + PM_AW'(3)) << 3;
            idx <= IDX_PTR0;
          end else if (idx == IDX_PTR3) begin
            idx   <= IDX_PAIRS;
            state <= ST_VREQ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_VREQ: state <= ST_VCAP;
        ST_VCAP: begin
          val_q <= mem_rd_data;
          idx   <= idx + 1'b1;
          state <= ST_AREQ;
        end
        ST_AREQ: state <= ST_ACAP;
        ST_ACAP: begin
          adr_q <= mem_rd_data;
          idx   <= idx + 1'b1;
          state <= ST_ISSUE;
        end
        ST_ISSUE: if (skip || dev_ready) state <= ST_NEXT;
        ST_NEXT: begin
          if (last)            state <= flags[FLG_DATA] ? ST_XSTART : ST_RESP;
          else if (idx >= lim) state <= ST_ERR;
          else                 state <= ST_VREQ;
        end
        ST_XSTART: state <= ST_XWAIT;
        ST_XWAIT:  if (xfer_done) state <= ST_RESP;
        ST_RESP:   state <= ST_IDLE;
        ST_ERR:    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    mem_rd_en   = (state == ST_HREQ) || (state == ST_VREQ) || (state == ST_AREQ);
    mem_rd_addr = idx;
    dev_valid   = (state == ST_ISSUE) && !skip;
    dev_addr    = reg_addr;
    dev_data    = val_q;
    xfer_start  = (state == ST_XSTART);
    mem_wr_en   = (state == ST_RESP);
    mem_wr_addr = '0;
    mem_wr_data = RESP_OK | (8'(dev_err) << RESP_DEVERR_BIT);
    irq         = (state == ST_RESP) && flags[FLG_IRQ];
    proto_err   = (state == ST_ERR);
  end

  // R7
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || eng_rst)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_addr) && $stable(dev_data));

  // R8
  xs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start && !mem_wr_en);

  // R12
  eng_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !busy && !mem_wr_en);

  // R2
  perr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !busy);

  // R11
  irq_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mem_wr_en && !dev_valid);
endmodule

// File: tb/tfs_seq_test.sv
module tfs_seq_test;
  localparam int PM_AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_rst = 1'b0, go = 1'b0, dev_ready = 1'b1, dev_err = 1'b0, xfer_done = 1'b0;
  logic busy, mem_rd_en, mem_wr_en, dev_valid, xfer_start, proto_err, irq;
  logic [PM_AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data = 8'h00, mem_wr_data, dev_data;
  logic [4:0] dev_addr;
  logic [31:0] xfer_ptr;

  always #10 clk = ~clk;

  tfs_seq #(.PM_AW(PM_AW)) uut (
    .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst), .go(go), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_addr(dev_addr), .dev_data(dev_data),
    .dev_err(dev_err), .xfer_start(xfer_start), .xfer_ptr(xfer_ptr), .xfer_done(xfer_done),
    .proto_err(proto_err), .irq(irq)
  );

  logic [7:0] pmem [0:255];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= pmem[mem_rd_addr[7:0]];
    if (mem_wr_en) pmem[mem_wr_addr[7:0]] <= mem_wr_data;
  end

  int checks = 0, fails = 0, cyc = 0;
  logic [12:0] exp_q [$];
  int wr_cnt = 0, resp_cnt = 0, pe_cnt = 0, xs_cnt = 0, resp_cyc = 0, done_cyc = 0;
  logic [7:0] resp_val = 8'h00;
  logic resp_irq = 1'b0;
  logic [31:0] xs_ptr = '0;
  int done_delay = 4, done_cnt = 0, stall_mode = 0;
  int hold_viol = 0;
  logic prev_stall = 1'b0;
  logic [12:0] prev_item = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard, evaluated mid-cycle
  always @(negedge clk) begin
    cyc++;
    dev_ready = (stall_mode != 0) ? ((cyc % 3) == 0) : 1'b1;
    if (prev_stall && !(dev_valid && {dev_addr, dev_data} == prev_item)) hold_viol++; // R7
    prev_stall = dev_valid && !dev_ready;
    prev_item = {dev_addr, dev_data};
    if (dev_valid && dev_ready) begin
      wr_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected write", {dev_addr, dev_data}, 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check({dev_addr, dev_data} == e, "R3 write order/content", {dev_addr, dev_data}, e);
      end
    end
    if (mem_wr_en) begin
      resp_cnt++; resp_val = mem_wr_data; resp_irq = irq; resp_cyc = cyc;
    end
    if (proto_err) pe_cnt++;
    xfer_done = 1'b0;
    if (xfer_start) begin
      xs_cnt++; xs_ptr = xfer_ptr; done_cnt = done_delay;
    end else if (done_cnt > 0) begin
      done_cnt--;
      if (done_cnt == 0) begin xfer_done = 1'b1; done_cyc = cyc; end
    end
  end

  task automatic clear_pkt();
    for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
    pmem[0] = 8'hAA;
    exp_q.delete();
    wr_cnt = 0; resp_cnt = 0; pe_cnt = 0; xs_cnt = 0; hold_viol = 0;
  endtask

  task automatic set_hdr(input logic [7:0] flg, input logic [7:0] len, input logic [31:0] ptr);
    pmem[2] = flg; pmem[3] = len;
    pmem[8] = ptr[7:0]; pmem[9] = ptr[15:8]; pmem[10] = ptr[23:16]; pmem[11] = ptr[31:24];
  endtask

  task automatic put_pair(input int k, input logic [7:0] v, input logic [7:0] a);
    pmem[16 + 2*k] = v;
    pmem[17 + 2*k] = a;
    if (!a[5]) exp_q.push_back({a[4:0], v});
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    clear_pkt();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !dev_valid && !mem_wr_en && !xfer_start && !proto_err && !irq,
          "R1 outputs after reset", {busy, dev_valid, mem_wr_en, xfer_start, proto_err, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Test A: 28-bit command, skip pad, irq set, no data (R3 R4 R5 R9 R10 R11)
    clear_pkt();
    set_hdr(8'h09, 8'd2, 32'h0);
    put_pair(0, 8'hE0, 8'h16);
    put_pair(1, 8'h08, 8'h12);
    put_pair(2, 8'h11, 8'h13);
    put_pair(3, 8'h22, 8'h14);
    put_pair(4, 8'h33, 8'h15);
    put_pair(5, 8'h00, 8'h0E);
    put_pair(6, 8'h00, 8'h20);
    put_pair(7, 8'hC8, 8'h97);
    pmem[32] = 8'h55; pmem[33] = 8'h16; // beyond end mark, must not be written
    pulse_go();
    wait_idle();
    check(exp_q.size() == 0 && wr_cnt == 7, "R4 skipped entry / R5 stop after end", wr_cnt, 7);
    check(resp_cnt == 1 && pmem[0] == 8'h01, "R10 response 0x01", pmem[0], 8'h01);
    check(resp_irq == 1'b1, "R11 irq with flag bit 3", resp_irq, 1);
    check(xs_cnt == 0, "R9 no xfer_start without data flag", xs_cnt, 0);

    // Test B: 48-bit command, data phase, stalls, device error (R7 R8 R10 R11)
    clear_pkt();
    set_hdr(8'h05, 8'd3, 32'h1234_5678);
    put_pair(0, 8'h40, 8'h16);
    put_pair(1, 8'h00, 8'h12);
    put_pair(2, 8'h01, 8'h13);
    put_pair(3, 8'h02, 8'h14);
    put_pair(4, 8'h03, 8'h15);
    put_pair(5, 8'h10, 8'h12);
    put_pair(6, 8'hA0, 8'h13);
    put_pair(7, 8'hB0, 8'h14);
    put_pair(8, 8'hC0, 8'h15);
    put_pair(9, 8'h00, 8'h0E);
    put_pair(10, 8'h00, 8'h20);
    put_pair(11, 8'h25, 8'h97);
    stall_mode = 1; dev_err = 1'b1; done_delay = 6;
    pulse_go();
    wait_idle();
    stall_mode = 0;
    check(exp_q.size() == 0 && wr_cnt == 11, "R3 all writes under stall", wr_cnt, 11);
    check(hold_viol == 0, "R7 hold while not ready", hold_viol, 0);
    check(xs_cnt == 1 && xs_ptr == 32'h1234_5678, "R8 descriptor pointer", xs_ptr, 32'h1234_5678);
    check(resp_cnt == 1 && resp_cyc > done_cyc, "R8 response after done", resp_cyc, done_cyc + 1);
    check(pmem[0] == 8'h09, "R10 device error code", pmem[0], 8'h09);
    check(resp_irq == 1'b0, "R11 no irq when flag clear", resp_irq, 0);
    dev_err = 1'b0;

    // Test C: invalid packet (R2)
    clear_pkt();
    set_hdr(8'h0C, 8'd2, 32'h0);
    put_pair(0, 8'h77, 8'h97);
    pulse_go();
    wait_idle();
    check(pe_cnt == 1, "R2 proto_err pulse", pe_cnt, 1);
    check(wr_cnt == 0 && resp_cnt == 0 && pmem[0] == 8'hAA, "R2 nothing written", wr_cnt + resp_cnt, 0);
    check(!busy, "R2 back to idle", busy, 0);

    // Test D: no end mark within length bound (R6)
    clear_pkt();
    set_hdr(8'h01, 8'd0, 32'h0);
    for (int k = 0; k < 6; k++) put_pair(k, 8'(k + 1), 8'h12);
    pulse_go();
    wait_idle();
    check(wr_cnt == 4, "R6 writes up to bound", wr_cnt, 4);
    check(pe_cnt == 1 && resp_cnt == 0 && pmem[0] == 8'hAA, "R6 error without response", pe_cnt, 1);

    // Test E: go while busy (R13)
    clear_pkt();
    set_hdr(8'h01, 8'd1, 32'h0);
    put_pair(0, 8'h5A, 8'h16);
    put_pair(1, 8'h24, 8'h97);
    stall_mode = 1;
    pulse_go();
    repeat (8) @(negedge clk);
    pulse_go();
    wait_idle();
    stall_mode = 0;
    repeat (20) @(negedge clk);
    check(wr_cnt == 2 && exp_q.size() == 0, "R13 no extra writes", wr_cnt, 2);
    check(resp_cnt == 1 && !busy, "R13 single completion", resp_cnt, 1);

    // Test F: engine reset during data wait (R12)
    clear_pkt();
    set_hdr(8'h0D, 8'd1, 32'hCAFE_0000);
    put_pair(0, 8'h99, 8'h97);
    done_delay = 1000;
    pulse_go();
    begin
      int n = 0;
      while (xs_cnt == 0 && n < 500) begin @(negedge clk); n++; end
    end
    repeat (3) @(negedge clk);
    eng_rst = 1'b1;
    @(negedge clk);
    eng_rst = 1'b0;
    check(!busy, "R12 idle after engine reset", busy, 0);
    repeat (10) @(negedge clk);
    check(resp_cnt == 0 && pmem[0] == 8'hAA, "R12 response byte untouched", pmem[0], 8'hAA);

    finish_run();
  end
endmodule